// File: doc/BRIEF.md
# Online Binary Perceptron Trainer

This block classifies a nine-pixel binary image into one of two classes and learns while it classifies. Every pixel, the label and the result are bipolar values (+1 or -1), and a tenth input, the bias, is fixed at +1. Each of the ten weights is held as two bounded, non-negative registers, a "raising" branch and a "lowering" branch. The effective weight is the raising branch minus the lowering branch.

For every accepted pattern, the block forms the signed weighted sum, takes its sign as the class, and compares the class with the label. When the class is wrong, it applies the perceptron rule: the raising branch of each weight moves one fixed step in the direction of x_i*d, and the lowering branch moves one step the other way. Each branch saturates at its own floor and ceiling.

A driver presents the patterns of a training set in shuffled order, one epoch after another. At the end of each epoch the block reports how many of that epoch's patterns it misclassified. It raises a sticky completion flag after the first epoch with no misclassification.

Top module: `perceptron_trainer`

## Requirements
- R1: While reset is asserted and after it, out_valid, err_count and done are 0. Every branch register starts at GINIT, so every effective weight starts at zero. in_ready rises two clock edges after rst_n is released.
- R2: Pixel bit value 1 encodes +1 and 0 encodes -1. Bit 0 of in_pixels is pixel 1, and the bias weight multiplies +1. out_class is 1 (+1) when the weighted sum is zero or greater, and 0 (-1) when it is negative.
- R3: A pattern is accepted on a clock edge where in_valid and in_ready are both 1. On the next cycle out_valid is 1 and out_class carries that pattern's class. out_miss is 1 exactly when the class differs from in_label (label bit 1 encodes +1).
- R4: On a misclassification, for each input i with value x_i (bias +1) and label d, the raising branch grows by 2*ALPHA and the lowering branch shrinks by 2*ALPHA when x_i*d = +1. When x_i*d = -1, the raising branch shrinks and the lowering branch grows by the same amount.
- R5: A correctly classified pattern leaves every branch register unchanged.
- R6: A branch register never leaves [GMIN, GMAX]. A step that would cross a bound stops at that bound.
- R7: After every EPOCH_LEN accepted patterns, err_count shows the number of misclassifications among them. It holds that value until the next epoch ends.
- R8: done rises at the end of the first epoch with zero misclassifications and stays high until reset.
- R9: A cycle without an accepted pattern changes neither the weights nor the epoch state, and is followed by out_valid = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pattern is offered |
| in_ready | output | 1 | Block can accept a pattern this cycle |
| in_pixels | input | N_PIX | Pixel values, 1 = +1, 0 = -1 |
| in_label | input | 1 | Desired class, 1 = +1, 0 = -1 |
| out_valid | output | 1 | Result of the previously accepted pattern |
| out_class | output | 1 | Computed class, 1 = +1, 0 = -1 |
| out_miss | output | 1 | Computed class differed from the label |
| err_count | output | CW | Misclassifications in the last completed epoch |
| done | output | 1 | An epoch with no misclassification has occurred |

## Verification
The assertions assume that in_valid, in_pixels and in_label are stable and defined whenever in_valid is high near a rising edge. They also assume that reset is held for at least one edge before the first pattern. The stimulus changes inputs only on falling edges and offers no pattern until in_ready has been high for several cycles. Stimulus comes in two phases. The first trains on a shuffled two-class set with idle gaps. The second uses random patterns with random labels, which keeps misclassifications frequent enough to drive branches into both bounds.

// File: rtl/perceptron_pkg.sv
package perceptron_pkg;
  // bipolar value carried on one bit
  typedef enum logic {BIP_NEG = 1'b0, BIP_POS = 1'b1} bip_e;

  // product of two bipolar values is +1 when the bits agree
  function automatic logic bip_agree(input logic a, input logic b);
    return ~(a ^ b);
  endfunction
endpackage

// File: rtl/pt_weight_pair.sv
module pt_weight_pair #(
  parameter int W     = 8,
  parameter int GMIN  = 5,
  parameter int GMAX  = 50,
  parameter int GINIT = 27,
  parameter int STEP  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         raise,
  output logic [W-1:0] p_q,
  output logic [W-1:0] n_q
);
  localparam logic [W-1:0] STEP_W = W'(STEP);
  localparam logic [W-1:0] HI_W   = W'(GMAX);
  localparam logic [W-1:0] LO_W   = W'(GMIN);
  localparam logic [W-1:0] INIT_W = W'(GINIT);
  localparam logic [W-1:0] HI_TH  = W'(GMAX - STEP);
  localparam logic [W-1:0] LO_TH  = W'(GMIN + STEP);

  logic [W-1:0] p_d, n_d;

  function automatic logic [W-1:0] step_up(input logic [W-1:0] v);
    return (v > HI_TH) ? HI_W : v + STEP_W;
  endfunction

  function automatic logic [W-1:0] step_dn(input logic [W-1:0] v);
    return (v < LO_TH) ? LO_W : v - STEP_W;
  endfunction

  always_comb begin
    p_d = p_q;
    n_d = n_q;
    if (upd_en) begin
      p_d = raise ? step_up(p_q) : step_dn(p_q);
      n_d = raise ? step_dn(n_q) : step_up(n_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= INIT_W;
      n_q <= INIT_W;
    end else if (upd_en) begin
      p_q <= p_d;
      n_q <= n_d;
    end
  end
endmodule

// File: rtl/pt_dot.sv
module pt_dot #(
  parameter int N_W = 10,
  parameter int W   = 8
) (
  input  logic [N_W-1:0]        x,
  input  logic [N_W-1:0][W-1:0] p_vec,
  input  logic [N_W-1:0][W-1:0] n_vec,
  output logic                  y_pos
);
  localparam int SW = W + 2 + $clog2(N_W);

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] term;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int i = 0; i < N_W; i++) begin
      term = $signed({{(SW-W){1'b0}}, p_vec[i]}) - $signed({{(SW-W){1'b0}}, n_vec[i]});
      if (x[i]) acc = acc + term;
      else      acc = acc - term;
    end
    y_pos = ~acc[SW-1];
  end
endmodule

// File: rtl/pt_epoch.sv
module pt_epoch #(
  parameter int LEN = 50,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          miss,
  output logic [CW-1:0] err_count,
  output logic          done
);
  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] errs_q, errs_d, errs_sum, err_d;
  logic          done_d;

  always_comb begin
    errs_sum = errs_q + CW'(miss);
    cnt_d    = cnt_q;
    errs_d   = errs_q;
    err_d    = err_count;
    done_d   = done;
    if (fire) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        errs_d = '0;
        err_d  = errs_sum;
        done_d = done | (errs_sum == '0);
      end else begin
        cnt_d  = cnt_q + 1'b1;
        errs_d = errs_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      errs_q    <= '0;
      err_count <= '0;
      done      <= 1'b0;
    end else if (fire) begin
      cnt_q     <= cnt_d;
      errs_q    <= errs_d;
      err_count <= err_d;
      done      <= done_d;
    end
  end
endmodule

// File: rtl/perceptron_trainer.sv
module perceptron_trainer #(
  parameter int N_PIX     = 9,
  parameter int W         = 8,
  parameter int GMIN      = 5,
  parameter int GMAX      = 50,
  parameter int GINIT     = 27,
  parameter int ALPHA     = 3,
  parameter int EPOCH_LEN = 50,
  parameter int CW        = $clog2(EPOCH_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_PIX-1:0] in_pixels,
  input  logic             in_label,
  output logic             out_valid,
  output logic             out_class,
  output logic             out_miss,
  output logic [CW-1:0]    err_count,
  output logic             done
);
  import perceptron_pkg::*;

  localparam int N_W  = N_PIX + 1;
  localparam int STEP = 2 * ALPHA;

  logic [1:0]                rs_q;
  logic                      rst_i;
  logic [N_W-1:0]            x_full;
  logic [N_W-1:0][W-1:0]     p_vec, n_vec;
  logic                      y_pos, fire, miss;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i    = rs_q[1];
  assign in_ready = rst_i;

  assign x_full = {in_pixels, BIP_POS};
  assign fire   = in_valid & in_ready;
  assign miss   = y_pos ^ in_label;

  pt_dot #(.N_W(N_W), .W(W)) u_dot (
    .x     (x_full),
    .p_vec (p_vec),
    .n_vec (n_vec),
    .y_pos (y_pos)
  );

  for (genvar g = 0; g < N_W; g++) begin : g_w
    pt_weight_pair #(
      .W(W), .GMIN(GMIN), .GMAX(GMAX), .GINIT(GINIT), .STEP(STEP)
    ) u_pair (
      .clk    (clk),
      .rst_n  (rst_i),
      .upd_en (fire & miss),
      .raise  (bip_agree(x_full[g], in_label)),
      .p_q    (p_vec[g]),
      .n_q    (n_vec[g])
    );
  end

  pt_epoch #(.LEN(EPOCH_LEN), .CW(CW)) u_epoch (
    .clk       (clk),
    .rst_n     (rst_i),
    .fire      (fire),
    .miss      (miss),
    .err_count (err_count),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid <= 1'b0;
      out_class <= 1'b0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_class <= y_pos;
        out_miss  <= miss;
      end
    end
  end
endmodule

// File: rtl/perceptron_trainer_chk.sv
module perceptron_trainer_chk #(
  parameter int N_W       = 10,
  parameter int W         = 8,
  parameter int GMIN      = 5,
  parameter int GMAX      = 50,
  parameter int EPOCH_LEN = 50,
  parameter int CW        = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fire,
  input logic                  miss,
  input logic                  out_valid,
  input logic                  done,
  input logic [CW-1:0]         err_count,
  input logic [N_W-1:0][W-1:0] p_vec,
  input logic [N_W-1:0][W-1:0] n_vec
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) fire |=> out_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> !out_valid); // R9
  AST_HOLD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) (fire && !miss) |=> ($stable(p_vec) && $stable(n_vec))); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R8
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) err_count <= CW'(EPOCH_LEN)); // R7

  for (genvar g = 0; g < N_W; g++) begin : g_rng
    AST_BRANCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vec[g] >= W'(GMIN)) && (p_vec[g] <= W'(GMAX)) && (n_vec[g] >= W'(GMIN)) && (n_vec[g] <= W'(GMAX))); // R6
  end
endmodule

bind perceptron_trainer perceptron_trainer_chk #(
  .N_W(N_W), .W(W), .GMIN(GMIN), .GMAX(GMAX), .EPOCH_LEN(EPOCH_LEN), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .fire      (fire),
  .miss      (miss),
  .out_valid (out_valid),
  .done      (done),
  .err_count (err_count),
  .p_vec     (p_vec),
  .n_vec     (n_vec)
);

// File: tb/tb_perceptron_trainer.sv
module tb_perceptron_trainer;
  localparam int CLK_PERIOD = 10;
  localparam int N_PIX = 9;
  localparam int GMIN = 5, GMAX = 50, GINIT = 27, ALPHA = 3, EPOCH_LEN = 50;
  localparam int CW = $clog2(EPOCH_LEN + 1);
  localparam int STEP = 2 * ALPHA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N_PIX-1:0] in_pixels = '0;
  logic in_label = 1'b0;
  logic in_ready, out_valid, out_class, out_miss, done;
  logic [CW-1:0] err_count;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int rp[0:N_PIX];
  int rn[0:N_PIX];
  int e_cnt, e_errs, e_err_count;
  bit e_valid, e_class, e_miss, e_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  perceptron_trainer #(
    .N_PIX(N_PIX), .GMIN(GMIN), .GMAX(GMAX), .GINIT(GINIT),
    .ALPHA(ALPHA), .EPOCH_LEN(EPOCH_LEN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixels(in_pixels), .in_label(in_label), .out_valid(out_valid),
    .out_class(out_class), .out_miss(out_miss), .err_count(err_count), .done(done)
  );

  function automatic int xval(input int k, input logic [N_PIX-1:0] px);
    if (k == 0) return 1;
    return px[k-1] ? 1 : -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= N_PIX; k++) begin rp[k] = GINIT; rn[k] = GINIT; end
      e_cnt = 0; e_errs = 0; e_err_count = 0;
      e_valid = 0; e_class = 0; e_miss = 0; e_done = 0;
    end else begin
      e_valid = 0;
      if (in_valid && in_ready) begin
        int s, y, d;
        s = 0;
        for (int k = 0; k <= N_PIX; k++) s += xval(k, in_pixels) * (rp[k] - rn[k]);
        y = (s >= 0) ? 1 : -1;
        d = in_label ? 1 : -1;
        e_valid = 1;
        e_class = (y == 1);
        e_miss  = (y != d);
        if (e_miss) begin
          for (int k = 0; k <= N_PIX; k++) begin
            if (xval(k, in_pixels) * d > 0) begin
              rp[k] = (rp[k] + STEP > GMAX) ? GMAX : rp[k] + STEP;
              rn[k] = (rn[k] - STEP < GMIN) ? GMIN : rn[k] - STEP;
            end else begin
              rp[k] = (rp[k] - STEP < GMIN) ? GMIN : rp[k] - STEP;
              rn[k] = (rn[k] + STEP > GMAX) ? GMAX : rn[k] + STEP;
            end
          end
        end
        e_errs += e_miss ? 1 : 0;
        e_cnt++;
        if (e_cnt == EPOCH_LEN) begin
          e_err_count = e_errs;
          if (e_errs == 0) e_done = 1;
          e_cnt = 0; e_errs = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // compare against the reference on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == e_valid, "R3 R9 out_valid", out_valid, e_valid);
      if (e_valid) begin
        check(out_class == e_class, "R2 R4 R6 out_class", out_class, e_class);
        check(out_miss == e_miss, "R3 R5 out_miss", out_miss, e_miss);
      end
      check(int'(err_count) == e_err_count, "R7 err_count", err_count, e_err_count);
      check(done == e_done, "R8 done", done, e_done);
    end
  end

  task automatic offer(input logic [N_PIX-1:0] px, input logic lbl, input int gap);
    in_valid = 1'b1; in_pixels = px; in_label = lbl;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle while held in reset
    check(out_valid == 1'b0 && done == 1'b0 && err_count == '0 && in_ready == 1'b0,
          "R1 reset state", {out_valid, done, in_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after release", in_ready, 1);
    repeat (3) @(negedge clk);
  endtask

  logic [N_PIX-1:0] set_px[0:EPOCH_LEN-1];
  logic             set_lb[0:EPOCH_LEN-1];
  int               order[0:EPOCH_LEN-1];

  initial begin
    logic [N_PIX-1:0] shape_x, shape_t;
    shape_x = 9'b101010101;
    shape_t = 9'b010010111;
    for (int k = 0; k < EPOCH_LEN; k++) begin
      set_lb[k] = k[0];
      set_px[k] = k[0] ? shape_x : shape_t;
      if (k >= 10) set_px[k][k % N_PIX] = ~set_px[k][k % N_PIX];
      order[k] = k;
    end

    do_reset();
    // R2: all weights zero, sum is zero, class must be +1 even for label -1
    in_valid = 1'b1; in_pixels = 9'b000000000; in_label = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_class == 1'b1 && out_miss == 1'b1, "R2 zero sum gives +1", out_class, 1);
    @(negedge clk);

    // phase 1: shuffled epochs of a two-class set
    for (int ep = 0; ep < 40 && !done; ep++) begin
      for (int k = EPOCH_LEN - 1; k > 0; k--) begin
        int j, t;
        j = $urandom_range(k, 0);
        t = order[k]; order[k] = order[j]; order[j] = t;
      end
      for (int k = 0; k < EPOCH_LEN; k++)
        offer(set_px[order[k]], set_lb[order[k]], ($urandom_range(3, 0) == 0) ? 1 : 0);
    end
    repeat (4) @(negedge clk);

    // phase 2: contradictory random traffic drives branches to the bounds (R4, R6)
    do_reset();
    for (int k = 0; k < 600; k++)
      offer(9'($urandom_range(511, 0)), 1'($urandom_range(1, 0)), $urandom_range(1, 0));
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule